// File: doc/BRIEF.md
# Multi-rail power sequencer

This block brings a six-rail peripral supply up and down in a fixed order. For each regulator it drives an enable line and watches that regulator's power-good line. It also drives an all-rails-good line and an active-low reset to the powered device. A one-cycle request pulse starts either the power-up or the power-down sequence. The block steps through the rails one at a time. It waits for each power-good line to reach the target level, and gives up after a timeout. A power-up that fails at any rail is unwound through the whole power-down sequence. A power-down that meets a stuck rail flags that rail and keeps going.

All waits are counted in millisecond ticks. An internal prescaler makes one tick every `CLK_PER_MS` clock cycles. Each rail has its own enable polarity, set by a mask parameter. Each rail also has its own settle time after it is switched off, set by a parameter vector. The power-good inputs pass through a two-flop synchronizer. The asynchronous reset is released in step with the clock.

Top module: `power_rail_sequencer`

## Requirements
- R1: Power-up switches on rail 0 (1.2 V), then rail 1 (1.8 V), rail 2 (3.3 V), rail 3 (core), rail 4 (PCIe) and rail 5 (frame buffer), one rail per step. At every cycle the set of rails switched on is a contiguous group that starts at rail 0.
- R2: On power-up, the next rail is enabled only after the power-good of the current rail reads high. On power-down, the next lower rail is disabled only after the current rail's power-good reads low, or after that rail has been flagged.
- R3: `rail_en[i]` equals the rail's logical on state, inverted when bit i of `EN_ACTIVE_LOW` is 1. When a rail is off, its enable therefore sits at `EN_ACTIVE_LOW[i]`.
- R4: A power-good wait that has not finished after `PG_TIMEOUT_MS` ticks (default 20) fails, and sets `rail_fault[i]` for that rail. Ticks come from a prescaler that pulses once every `CLK_PER_MS` cycles.
- R5: Power-down runs from rail 5 down to rail 0. After each rail it holds a settle time of 0, 10, 2, 4, 0 and 0 ms, listed for rails 5, 4, 3, 2, 1 and 0 in that order.
- R6: `dev_rst_n` is low whenever a power-up enables its first rail.
- R7: When a power-up fails, the block runs the full power-down sequence and ends in the off state. During that attempt `rails_good` never rises and `dev_rst_n` never goes high.
- R8: After all six rails are good, `rails_good` rises. One tick later `dev_rst_n` goes high. One tick after that `powered` rises. While `powered` is high, `rails_good` and `dev_rst_n` are high and every rail is on.
- R9: Power-down first drives `dev_rst_n` low, then drops `rails_good` one cycle later, then sequences the rails. A rail whose power-good stays high is flagged, and the remaining rails are still switched off.
- R10: `busy` is high from the cycle after an accepted request until the off or powered state is reached. Any request that arrives while `busy` is high is ignored. An on request while powered is ignored, and so is an off request while off.
- R11: Fault flags stay set until the next accepted on request, which clears them all.
- R12: After reset, every rail is off, `dev_rst_n` and `rails_good` are low, `busy` and `powered` are low, and there are no faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | One-cycle power-up request |
| off_req | input | 1 | One-cycle power-down request |
| pg_in | input | NUM_RAILS | Regulator power-good lines, bit i for rail i |
| rail_en | output | NUM_RAILS | Regulator enables, with the polarity set by EN_ACTIVE_LOW |
| dev_rst_n | output | 1 | Active-low reset to the powered device |
| rails_good | output | 1 | All rails good, driven to the device |
| busy | output | 1 | A sequence is running |
| powered | output | 1 | Power-up has completed |
| rail_fault | output | NUM_RAILS | Latched power-good timeout, one flag per rail |

## Verification
The assertions check a set of invariants on every cycle:
- the switched-on rails always form a contiguous group starting at rail 0, and change one rail at a time;
- the device reset is never released without `rails_good`;
- an aborting power-up never shows `rails_good` or a released reset;
- reset is low when the first rail comes on;
- the wait timer never passes its limit;
- the powered state implies the full output set.

Some behaviour only the bench scenarios can show:
- the measured timeout and settle windows in ticks;
- the enable polarity and the fault patterns left behind by stuck-low and stuck-high regulators;
- fault clearing on the next power-up;
- requests being ignored while busy.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [3:0] {
    ST_OFF,
    ST_UP_EN,
    ST_UP_WAIT,
    ST_UP_GOOD,
    ST_UP_REL,
    ST_ON,
    ST_DN_RST,
    ST_DN_GOOD,
    ST_DN_EN,
    ST_DN_WAIT,
    ST_DN_SET
  } seq_state_e;
endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= d[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/rseq_tick.sv
module rseq_tick #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == TOP);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

  if (DIV > 1) begin : g_gap
    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] limit,
  output logic          expired
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] lim_q, lim_d;
  logic          cnt_en;

  assign cnt_en = tick && (cnt_q != lim_q);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (start) begin
      cnt_d = '0;
      lim_d = limit;
    end else if (cnt_en) begin
      cnt_d = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign expired = (cnt_q == lim_q);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int N             = 6,
  parameter int DW            = 8,
  parameter int PG_TIMEOUT_MS = 20,
  parameter logic [N*DW-1:0] SETTLE_MS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_req,
  input  logic          off_req,
  input  logic [N-1:0]  pg,
  input  logic          tmr_expired,
  output logic          tmr_start,
  output logic [DW-1:0] tmr_limit,
  output logic [N-1:0]  rail_on,
  output logic          dev_rst_n,
  output logic          rails_good,
  output logic          busy,
  output logic          powered,
  output logic [N-1:0]  fault
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST  = IW'(N - 1);
  localparam logic [DW-1:0] TMO_V = DW'(PG_TIMEOUT_MS);
  localparam logic [DW-1:0] ONE_V = DW'(1);

  seq_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [N-1:0]  on_q, on_d;
  logic [N-1:0]  flt_q, flt_d;
  logic          rst_q, rst_d;
  logic          good_q, good_d;
  logic          abort_q, abort_d;
  logic          pg_cur;

  assign pg_cur = pg[idx_q];

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    on_d      = on_q;
    flt_d     = flt_q;
    rst_d     = rst_q;
    good_d    = good_q;
    abort_d   = abort_q;
    tmr_start = 1'b0;
    tmr_limit = TMO_V;
    unique case (st_q)
      ST_OFF: begin
        if (on_req) begin
          flt_d   = '0;
          abort_d = 1'b0;
          rst_d   = 1'b0;
          idx_d   = '0;
          st_d    = ST_UP_EN;
        end
      end
      ST_UP_EN: begin
        on_d[idx_q] = 1'b1;
        tmr_start   = 1'b1;
        st_d        = ST_UP_WAIT;
      end
      ST_UP_WAIT: begin
        if (pg_cur) begin
          if (idx_q == LAST) begin
            good_d    = 1'b1;
            tmr_start = 1'b1;
            tmr_limit = ONE_V;
            st_d      = ST_UP_GOOD;
          end else begin
            idx_d = idx_q + IW'(1);
            st_d  = ST_UP_EN;
          end
        end else if (tmr_expired) begin
          flt_d[idx_q] = 1'b1;
          abort_d      = 1'b1;
          st_d         = ST_DN_RST;
        end
      end
      ST_UP_GOOD: begin
        if (tmr_expired) begin
          rst_d     = 1'b1;
          tmr_start = 1'b1;
          tmr_limit = ONE_V;
          st_d      = ST_UP_REL;
        end
      end
      ST_UP_REL: begin
        if (tmr_expired) st_d = ST_ON;
      end
      ST_ON: begin
        if (off_req) begin
          abort_d = 1'b0;
          st_d    = ST_DN_RST;
        end
      end
      ST_DN_RST: begin
        rst_d = 1'b0;
        st_d  = ST_DN_GOOD;
      end
      ST_DN_GOOD: begin
        good_d = 1'b0;
        idx_d  = LAST;
        st_d   = ST_DN_EN;
      end
      ST_DN_EN: begin
        on_d[idx_q] = 1'b0;
        tmr_start   = 1'b1;
        st_d        = ST_DN_WAIT;
      end
      ST_DN_WAIT: begin
        if (!pg_cur || tmr_expired) begin
          if (pg_cur) flt_d[idx_q] = 1'b1;
          tmr_start = 1'b1;
          tmr_limit = SETTLE_MS[int'(idx_q)*DW +: DW];
          st_d      = ST_DN_SET;
        end
      end
      ST_DN_SET: begin
        if (tmr_expired) begin
          if (idx_q == '0) begin
            abort_d = 1'b0;
            st_d    = ST_OFF;
          end else begin
            idx_d = idx_q - IW'(1);
            st_d  = ST_DN_EN;
          end
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      idx_q   <= '0;
      on_q    <= '0;
      flt_q   <= '0;
      rst_q   <= 1'b0;
      good_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      on_q    <= on_d;
      flt_q   <= flt_d;
      rst_q   <= rst_d;
      good_q  <= good_d;
      abort_q <= abort_d;
    end
  end

  assign rail_on    = on_q;
  assign fault      = flt_q;
  assign dev_rst_n  = rst_q;
  assign rails_good = good_q;
  assign powered    = (st_q == ST_ON);
  assign busy       = (st_q != ST_ON) && (st_q != ST_OFF);

  // R1
  thermo_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((on_q + N'(1)) & on_q) == '0);
  // R1
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(on_q ^ $past(on_q)) <= 1);
  // R6
  rst_before_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q[0]) |-> !rst_q);
  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (!good_q && !rst_q));
  // R8
  rst_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> good_q);
  // R8
  powered_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powered |-> (rst_q && good_q && (&on_q)));
  // R10
  ready_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered) |-> $past(busy));
endmodule

// File: rtl/power_rail_sequencer.sv
module power_rail_sequencer #(
  parameter int NUM_RAILS     = 6,
  parameter int CLK_PER_MS    = 100000,
  parameter int DLY_W         = 8,
  parameter int PG_TIMEOUT_MS = 20,
  parameter logic [NUM_RAILS-1:0] EN_ACTIVE_LOW = '0,
  parameter logic [NUM_RAILS*DLY_W-1:0] SETTLE_MS =
    {8'd0, 8'd10, 8'd2, 8'd4, 8'd0, 8'd0}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 on_req,
  input  logic                 off_req,
  input  logic [NUM_RAILS-1:0] pg_in,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 dev_rst_n,
  output logic                 rails_good,
  output logic                 busy,
  output logic                 powered,
  output logic [NUM_RAILS-1:0] rail_fault
);
  logic [1:0]           rst_sync_q;
  logic                 rst_core_n;
  logic [NUM_RAILS-1:0] pg_sync;
  logic [NUM_RAILS-1:0] rail_on;
  logic                 ms_tick;
  logic                 tmr_start;
  logic [DLY_W-1:0]     tmr_limit;
  logic                 tmr_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rseq_sync #(.W(NUM_RAILS)) u_pg_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .d    (pg_in),
    .q    (pg_sync)
  );

  rseq_tick #(.DIV(CLK_PER_MS)) u_tick (
    .clk  (clk),
    .rst_n(rst_core_n),
    .tick (ms_tick)
  );

  rseq_timer #(.DW(DLY_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick   (ms_tick),
    .start  (tmr_start),
    .limit  (tmr_limit),
    .expired(tmr_expired)
  );

  rseq_ctrl #(
    .N            (NUM_RAILS),
    .DW           (DLY_W),
    .PG_TIMEOUT_MS(PG_TIMEOUT_MS),
    .SETTLE_MS    (SETTLE_MS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .on_req     (on_req),
    .off_req    (off_req),
    .pg         (pg_sync),
    .tmr_expired(tmr_expired),
    .tmr_start  (tmr_start),
    .tmr_limit  (tmr_limit),
    .rail_on    (rail_on),
    .dev_rst_n  (dev_rst_n),
    .rails_good (rails_good),
    .busy       (busy),
    .powered    (powered),
    .fault      (rail_fault)
  );

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_pol
    if (EN_ACTIVE_LOW[g]) begin : g_low
      assign rail_en[g] = ~rail_on[g];
    end else begin : g_high
      assign rail_en[g] = rail_on[g];
    end
  end

  // R3
  polarity_on_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    powered |-> (rail_en == ~EN_ACTIVE_LOW));
endmodule

// File: tb/power_rail_sequencer_tb.sv
module power_rail_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 16;
  localparam int N    = 6;
  localparam logic [N-1:0] MASK = 6'b100001;

  typedef struct packed {
    logic         go_up;
    logic [N-1:0] lo;
    logic [N-1:0] hi;
    logic         pwr;
    logic [N-1:0] flt;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'h00, 6'h00, 1'b1, 6'h00},
    '{1'b0, 6'h00, 6'h00, 1'b0, 6'h00},
    '{1'b1, 6'h08, 6'h00, 1'b0, 6'h08},
    '{1'b1, 6'h00, 6'h00, 1'b1, 6'h00},
    '{1'b0, 6'h00, 6'h10, 1'b0, 6'h10},
    '{1'b1, 6'h01, 6'h00, 1'b0, 6'h01},
    '{1'b1, 6'h20, 6'h00, 1'b0, 6'h20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0;
  logic off_req = 1'b0;
  logic [N-1:0] pg;
  logic [N-1:0] rail_en;
  logic dev_rst_n, rails_good, busy, powered;
  logic [N-1:0] rail_fault;

  logic [N-1:0] stuck_lo = '0;
  logic [N-1:0] stuck_hi = '0;
  logic [N-1:0] lat1 = '0;
  logic [N-1:0] lat2 = '0;
  logic [N-1:0] lat3 = '0;
  logic [N-1:0] on_now;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int cyc = 0;
  int t_on [N];
  int t_off [N];
  int t_good_rise = 0, t_rst_rise = 0, t_pwr_rise = 0, t_flt = 0;
  int t_rst_fall = 0, t_good_fall = 0;
  int err_order = 0, err_pg = 0, err_rst = 0;
  bit saw_good = 1'b0, saw_rel = 1'b0;
  logic [N-1:0] prev_on = '0;
  logic [N-1:0] prev_flt = '0;
  logic prev_good = 1'b0, prev_rst = 1'b0, prev_pwr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  power_rail_sequencer #(
    .NUM_RAILS    (N),
    .CLK_PER_MS   (DIV),
    .EN_ACTIVE_LOW(MASK)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_req    (on_req),
    .off_req   (off_req),
    .pg_in     (pg),
    .rail_en   (rail_en),
    .dev_rst_n (dev_rst_n),
    .rails_good(rails_good),
    .busy      (busy),
    .powered   (powered),
    .rail_fault(rail_fault)
  );

  assign on_now = rail_en ^ MASK;
  assign pg = (lat3 & ~stuck_lo) | stuck_hi;

  always @(negedge clk) begin
    lat1 <= on_now;
    lat2 <= lat1;
    lat3 <= lat2;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < N; i++) begin
      if (on_now[i] && !prev_on[i]) begin
        t_on[i] = cyc;
        if (dev_rst_n) err_rst = err_rst + 1;
        for (int j = 0; j < i; j++) begin
          if (!on_now[j]) err_order = err_order + 1;
          if (!pg[j]) err_pg = err_pg + 1;
        end
        for (int j = i + 1; j < N; j++)
          if (on_now[j]) err_order = err_order + 1;
      end
      if (!on_now[i] && prev_on[i]) begin
        t_off[i] = cyc;
        for (int j = i + 1; j < N; j++)
          if (on_now[j]) err_order = err_order + 1;
        if (i < N - 1)
          if (pg[i+1] && !rail_fault[i+1]) err_pg = err_pg + 1;
      end
    end
    if (rails_good && !prev_good) begin t_good_rise = cyc; saw_good = 1'b1; end
    if (!rails_good && prev_good) t_good_fall = cyc;
    if (dev_rst_n && !prev_rst) begin t_rst_rise = cyc; saw_rel = 1'b1; end
    if (!dev_rst_n && prev_rst) t_rst_fall = cyc;
    if (powered && !prev_pwr) t_pwr_rise = cyc;
    if ((rail_fault != '0) && (prev_flt == '0)) t_flt = cyc;
    prev_on   = on_now;
    prev_flt  = rail_fault;
    prev_good = rails_good;
    prev_rst  = dev_rst_n;
    prev_pwr  = powered;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk = n_chk + 1;
    if (act < lo || act > hi) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic pulse_on();
    @(negedge clk) on_req = 1'b1;
    @(negedge clk) on_req = 1'b0;
  endtask

  task automatic pulse_off();
    @(negedge clk) off_req = 1'b1;
    @(negedge clk) off_req = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 5000) begin
      @(negedge clk);
      k = k + 1;
    end
    chk(!busy, "R10 sequence end", int'(busy), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R12 reset state
    chk(rail_en == MASK, "R12 rail_en", int'(rail_en), int'(MASK));
    chk(!dev_rst_n, "R12 dev_rst_n", int'(dev_rst_n), 0);
    chk(!rails_good, "R12 rails_good", int'(rails_good), 0);
    chk(!busy && !powered, "R12 busy/powered", int'({busy, powered}), 0);
    chk(rail_fault == '0, "R12 rail_fault", int'(rail_fault), 0);

    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = VEC[v].go_up ? (VEC[v].pwr ? "R8" : "R7") : "R9";
      stuck_lo = VEC[v].lo;
      stuck_hi = VEC[v].hi;
      saw_good = 1'b0;
      saw_rel  = 1'b0;
      repeat (10) @(negedge clk);
      if (VEC[v].go_up) pulse_on();
      else pulse_off();
      chk(busy, "R10 busy after request", int'(busy), 1);
      wait_idle();
      repeat (40) @(negedge clk);
      chk(powered == VEC[v].pwr, {tg, " powered"}, int'(powered), int'(VEC[v].pwr));
      chk(rail_fault == VEC[v].flt, "R11 rail_fault", int'(rail_fault), int'(VEC[v].flt));
      chk(rail_en == (VEC[v].pwr ? ~MASK : MASK), "R3 rail_en", int'(rail_en),
          int'(VEC[v].pwr ? ~MASK : MASK));
      chk(rails_good == VEC[v].pwr, {tg, " rails_good"}, int'(rails_good), int'(VEC[v].pwr));
      chk(dev_rst_n == VEC[v].pwr, {tg, " dev_rst_n"}, int'(dev_rst_n), int'(VEC[v].pwr));
      if (VEC[v].go_up && !VEC[v].pwr) begin
        chk(!saw_good, "R7 rails_good seen", int'(saw_good), 0);
        chk(!saw_rel, "R7 reset released", int'(saw_rel), 0);
      end
      if (v == 0) begin
        chk_rng("R8 good to reset release", t_rst_rise - t_good_rise, 1, DIV + 2);
        chk_rng("R8 release to powered", t_pwr_rise - t_rst_rise, 1, DIV + 2);
      end
      if (v == 1) begin
        chk(t_rst_fall < t_good_fall, "R9 reset before good drop", t_rst_fall, t_good_fall);
        chk(t_good_fall < t_off[5], "R9 good drop before rails", t_good_fall, t_off[5]);
        chk_rng("R5 settle rail5", t_off[4] - t_off[5], 1, DIV - 1);
        chk_rng("R5 settle rail4", t_off[3] - t_off[4], 9 * DIV, 10 * DIV + 24);
        chk_rng("R5 settle rail3", t_off[2] - t_off[3], DIV, 2 * DIV + 24);
        chk_rng("R5 settle rail2", t_off[1] - t_off[2], 3 * DIV, 4 * DIV + 24);
      end
      if (v == 2)
        chk_rng("R4 timeout window", t_flt - t_on[3], 19 * DIV, 20 * DIV + 4);
    end
    stuck_lo = '0;
    stuck_hi = '0;
    repeat (10) @(negedge clk);

    // R10 off request during power-up is ignored
    pulse_on();
    repeat (20) @(negedge clk);
    pulse_off();
    wait_idle();
    chk(powered, "R10 off ignored while busy", int'(powered), 1);
    // R10 on request while powered is ignored
    pulse_on();
    chk(!busy, "R10 on while powered", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(powered, "R10 stays powered", int'(powered), 1);
    // R10 on request during power-down is ignored
    pulse_off();
    repeat (20) @(negedge clk);
    pulse_on();
    wait_idle();
    repeat (10) @(negedge clk);
    chk(!powered && rail_en == MASK, "R10 on ignored while busy", int'(rail_en), int'(MASK));
    // R10 off request while off is ignored
    pulse_off();
    chk(!busy, "R10 off while off", int'(busy), 0);

    chk(err_order == 0, "R1 rail order", err_order, 0);
    chk(err_pg == 0, "R2 power-good gating", err_pg, 0);
    chk(err_rst == 0, "R6 reset at rail enable", err_rst, 0);
    finish_run();
  end
endmodule